// File: doc/BRIEF.md
# Wake-Sleep Controller with Failsafe Watchdog

This block is the power-state controller on the device side of a single-wire authentication peripheral. It keeps the device in a low-power sleep state until the line decoder reports a wake token. Once the device is awake, the block runs two timers. The first is an inactivity timer that sends the device back to sleep when the line stays quiet for too long. The second is a failsafe watchdog that forces sleep a fixed number of cycles after wake, whatever else is happening.

The line decoder supplies single-cycle strobes: one for a wake token, one for any token, and one for a transmit token. The command engine supplies a busy level. While busy is high, the inactivity timer is held off, but the watchdog keeps counting. Nothing can restart the watchdog except a sleep followed by a new wake. The first transmit token after a wake asks the output path to send the fixed wake status byte 0x11. Each entry into sleep raises a one-cycle pulse that clears the state machines downstream.

Top module: `wake_sleep_ctrl`

## Requirements
- R1: After a synchronous active-low reset the device is asleep: `awake_o`, `clk_en_o`, `sleep_pulse_o` and `status_req_o` are all 0, and `status_code_o` is 8'h00.
- R2: A `wake_det_i` strobe while asleep makes `awake_o` and `clk_en_o` 1 from the next cycle on. The device only becomes awake after such a strobe.
- R3: If `tok_i` stays low and `busy_i` stays low, the device sleeps again after exactly `IO_TMO_CYC` awake cycles. No status request is raised.
- R4: A `tok_i` strobe during an awake, non-busy cycle restarts the inactivity count. The device then stays awake for another `IO_TMO_CYC` cycles after that cycle.
- R5: While `busy_i` is 1, the inactivity timer cannot end the awake period. It starts again from zero on the first cycle after busy drops.
- R6: The device is awake for at most `WDOG_CYC` consecutive cycles. If it is held awake, it sleeps after exactly `WDOG_CYC` cycles, even while busy or while tokens keep arriving.
- R7: A `wake_det_i` strobe while the device is awake has no effect. In particular, it does not restart the watchdog.
- R8: The first `xmit_i` strobe in an awake period sets `status_req_o` for exactly the next cycle, with `status_code_o` = 8'h11 in that cycle; `status_code_o` is 8'h00 whenever `status_req_o` is 0. Later `xmit_i` strobes in the same awake period raise no request.
- R9: `sleep_pulse_o` is 1 for exactly one cycle: the first asleep cycle after an awake period.
- R10: While the device is asleep, `tok_i`, `xmit_i` and `busy_i` are ignored. The device stays asleep and raises no status request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, forces sleep |
| wake_det_i | input | 1 | Wake-token detect strobe from the line decoder |
| tok_i | input | 1 | Strobe for any received token |
| xmit_i | input | 1 | Strobe for a received transmit token |
| busy_i | input | 1 | Command engine is executing |
| awake_o | output | 1 | 1 when the device is awake |
| clk_en_o | output | 1 | Clock-gate enable for the device core |
| sleep_pulse_o | output | 1 | One-cycle pulse on sleep entry |
| status_req_o | output | 1 | Request to send the wake status byte |
| status_code_o | output | 8 | Wake status byte, 8'h11 while requested |

## Verification
Every cycle, the assertions check the following bounds:
- no awake run lasts longer than the watchdog limit;
- no awake run lasts longer than the inactivity limit without a token or busy;
- each rise to awake is preceded by a wake strobe;
- the sleep pulse matches the falling edge of the awake state;
- each status request carries the code 0x11 and comes from an awake cycle.

Only the bench scenarios can show the following:
- the exact lengths of awake runs;
- that a token or the end of busy really restarts the inactivity period;
- that a wake strobe during an awake period leaves the watchdog deadline unchanged;
- that only the first transmit token of each wake raises a request.

// File: rtl/wsc_pkg.sv
// Package: shared constants and types for the wake-sleep controller.
// Assumes nothing beyond being compiled before the modules that import it.
package wsc_pkg;
    // Fixed byte reported on the first transmit after a wake
    localparam logic [7:0] WSC_WAKE_STATUS = 8'h11;
    // Power state of the device
    typedef enum logic {
        PWR_SLEEP = 1'b0,
        PWR_AWAKE = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/wsc_wdog.sv
// Module: failsafe watchdog. Counts awake cycles from zero and flags
// expiry on the last allowed cycle. Only leaving the awake state clears it.
// Assumes LIMIT >= 2 and that clear_i is asserted on the sleep-entry cycle.
module wsc_wdog #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic awake_i,
    input  logic clear_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count while awake, return to zero when asleep or leaving awake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!awake_i || clear_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry on the final awake cycle
    always_comb begin
        expire_o = awake_i && (cnt_q == LAST);
    end
endmodule

// File: rtl/wsc_idle_tmo.sv
// Module: line-inactivity timer. It counts quiet awake cycles. Activity or
// busy holds the count at zero, and expiry is flagged on the last quiet cycle.
// Assumes LIMIT >= 2 and that clear_i is asserted on the sleep-entry cycle.
module wsc_idle_tmo #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic awake_i,
    input  logic clear_i,
    input  logic activity_i,
    input  logic busy_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          hold;

    // Busy suppresses the timer, a token restarts it
    always_comb begin
        hold = busy_i || activity_i;
    end

    // Quiet-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!awake_i || clear_i || hold) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry when the last quiet cycle passes without activity or busy
    always_comb begin
        expire_o = awake_i && !hold && (cnt_q == LAST);
    end
endmodule

// File: rtl/wsc_status.sv
// Module: wake-status request. Arms at wake and answers the first transmit
// token of the awake period with a one-cycle request carrying the fixed code.
// Assumes xmit_i is a single-cycle strobe.
module wsc_status
    import wsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       awake_i,
    input  logic       wake_i,
    input  logic       xmit_i,
    input  logic       clear_i,
    output logic       req_o,
    output logic [7:0] code_o
);
    logic pend_q;
    logic req_q;

    // Pending flag: set on wake from sleep, dropped by the first transmit or by sleep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!awake_i) begin
            pend_q <= wake_i;
        end else if (xmit_i || clear_i) begin
            pend_q <= 1'b0;
        end
    end

    // One-cycle request after the first transmit token
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= awake_i && pend_q && xmit_i;
        end
    end

    // Code is driven only while requested
    always_comb begin
        req_o  = req_q;
        code_o = req_q ? WSC_WAKE_STATUS : 8'h00;
    end
endmodule

// File: rtl/wake_sleep_ctrl.sv
// Module: top of the wake-sleep controller. Holds the power state and
// enters sleep on watchdog or inactivity expiry. Emits the clock enable, the
// sleep-entry pulse and the wake-status request.
// Assumes the decoder strobes are one cycle wide and synchronous to clk,
// and IO_TMO_CYC < WDOG_CYC.
module wake_sleep_ctrl
    import wsc_pkg::*;
#(
    parameter int IO_TMO_CYC = 64,
    parameter int WDOG_CYC   = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_det_i,
    input  logic       tok_i,
    input  logic       xmit_i,
    input  logic       busy_i,
    output logic       awake_o,
    output logic       clk_en_o,
    output logic       sleep_pulse_o,
    output logic       status_req_o,
    output logic [7:0] status_code_o
);
    // Elaboration-time check of the limit ordering
    generate
        if (IO_TMO_CYC < 2 || IO_TMO_CYC >= WDOG_CYC) begin : g_bad_limits
            $error("wake_sleep_ctrl: need 2 <= IO_TMO_CYC < WDOG_CYC");
        end
    endgenerate

    pwr_state_e state_q;
    logic       awake;
    logic       wdog_exp;
    logic       idle_exp;
    logic       sleep_now;
    logic       spulse_q;

    // Decode the current state and the sleep decision
    always_comb begin
        awake     = (state_q == PWR_AWAKE);
        sleep_now = awake && (wdog_exp || idle_exp);
    end

    // Power-state register: wake only from sleep, sleep on any expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PWR_SLEEP;
        end else if (!awake) begin
            state_q <= wake_det_i ? PWR_AWAKE : PWR_SLEEP;
        end else if (sleep_now) begin
            state_q <= PWR_SLEEP;
        end
    end

    // Sleep-entry pulse on the first asleep cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spulse_q <= 1'b0;
        end else begin
            spulse_q <= sleep_now;
        end
    end

    wsc_wdog #(
        .LIMIT(WDOG_CYC)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .awake_i (awake),
        .clear_i (sleep_now),
        .expire_o(wdog_exp)
    );

    wsc_idle_tmo #(
        .LIMIT(IO_TMO_CYC)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .awake_i   (awake),
        .clear_i   (sleep_now),
        .activity_i(tok_i),
        .busy_i    (busy_i),
        .expire_o  (idle_exp)
    );

    wsc_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .awake_i(awake),
        .wake_i (wake_det_i),
        .xmit_i (xmit_i),
        .clear_i(sleep_now),
        .req_o  (status_req_o),
        .code_o (status_code_o)
    );

    // Output drive
    always_comb begin
        awake_o       = awake;
        clk_en_o      = awake;
        sleep_pulse_o = spulse_q;
    end
endmodule

// File: rtl/wsc_checker.sv
// Module: property checker for wake_sleep_ctrl, attached by bind.
// It keeps its own run-length counters so that the limits are checked
// without deep $past.
module wsc_checker #(
    parameter int IO_TMO_CYC = 64,
    parameter int WDOG_CYC   = 256
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_det_i,
    input logic       tok_i,
    input logic       busy_i,
    input logic       awake_o,
    input logic       sleep_pulse_o,
    input logic       status_req_o,
    input logic [7:0] status_code_o
);
    int unsigned awake_run;
    int unsigned quiet_run;

    // Count consecutive awake cycles and consecutive quiet awake cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            awake_run <= 0;
            quiet_run <= 0;
        end else begin
            awake_run <= awake_o ? awake_run + 1 : 0;
            quiet_run <= (awake_o && !busy_i && !tok_i) ? quiet_run + 1 : 0;
        end
    end

    assert_wake_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(awake_o) |-> $past(wake_det_i));

    assert_idle_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        awake_o |-> (quiet_run < IO_TMO_CYC));

    assert_wdog_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        awake_o |-> (awake_run < WDOG_CYC));

    assert_status_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_req_o |-> (status_code_o == 8'h11 && $past(awake_o)));

    assert_status_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_req_o |=> !status_req_o);

    assert_sleep_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_pulse_o == (!awake_o && $past(awake_o)));
endmodule

bind wake_sleep_ctrl wsc_checker #(
    .IO_TMO_CYC(IO_TMO_CYC),
    .WDOG_CYC  (WDOG_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake_det_i   (wake_det_i),
    .tok_i        (tok_i),
    .busy_i       (busy_i),
    .awake_o      (awake_o),
    .sleep_pulse_o(sleep_pulse_o),
    .status_req_o (status_req_o),
    .status_code_o(status_code_o)
);

// File: tb/wake_sleep_ctrl_tb.sv
// Bench: directed corner cases followed by seeded random stimulus.
// A cycle model built from the requirements is compared every cycle.
module wake_sleep_ctrl_tb;
    localparam int IO = 16;
    localparam int WD = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake = 1'b0, tok = 1'b0, xmit = 1'b0, busy = 1'b0;
    logic       awake_o, clk_en_o, sleep_pulse_o, status_req_o;
    logic [7:0] status_code_o;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    int cyc = 0;

    // Model state
    bit m_awake = 0, m_sp = 0, m_sr = 0, m_pend = 0;
    int m_wd = 0, m_io = 0;

    wake_sleep_ctrl #(.IO_TMO_CYC(IO), .WDOG_CYC(WD)) u_dut (
        .clk(clk), .rst_n(rst_n), .wake_det_i(wake), .tok_i(tok),
        .xmit_i(xmit), .busy_i(busy), .awake_o(awake_o), .clk_en_o(clk_en_o),
        .sleep_pulse_o(sleep_pulse_o), .status_req_o(status_req_o),
        .status_code_o(status_code_o)
    );

    always #2 clk = ~clk;  // 250 MHz

    function automatic bit wd_expired(int cnt);
        return cnt == WD - 1;
    endfunction

    function automatic bit io_expired(int cnt, bit b, bit t);
        return !b && !t && cnt == IO - 1;
    endfunction

    // Reference model, updated at each rising edge from the requirements
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_awake = 0; m_sp = 0; m_sr = 0; m_pend = 0; m_wd = 0; m_io = 0;
        end else if (!m_awake) begin
            m_awake = wake; m_pend = wake; m_sp = 0; m_sr = 0; m_wd = 0; m_io = 0;
        end else begin
            m_sr = m_pend && xmit;
            if (xmit) m_pend = 0;
            if (wd_expired(m_wd) || io_expired(m_io, busy, tok)) begin
                m_awake = 0; m_sp = 1; m_wd = 0; m_io = 0; m_pend = 0;
            end else begin
                m_sp = 0; m_wd++; m_io = (busy || tok) ? 0 : m_io + 1;
            end
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check(awake_o == m_awake, "R3", "awake_o", awake_o, m_awake);
            check(clk_en_o == m_awake, "R2", "clk_en_o", clk_en_o, m_awake);
            check(sleep_pulse_o == m_sp, "R9", "sleep_pulse_o", sleep_pulse_o, m_sp);
            check(status_req_o == m_sr, "R8", "status_req_o", status_req_o, m_sr);
            check(status_code_o == (m_sr ? 8'h11 : 8'h00), "R8", "status_code_o",
                  status_code_o, m_sr ? 8'h11 : 8'h00);
        end
    end

    task automatic step(bit w, bit t, bit x, bit b);
        wake = w; tok = t; xmit = x; busy = b;
        @(negedge clk);
    endtask

    // Wake the device and count its awake cycles under a stimulus mode
    // mode 0: quiet, 1: token at cycle IO-1, 2: busy first 3*IO, 3: busy always,
    // 4: busy always plus wake strobes
    task automatic awake_len(int mode, output int len);
        step(1, 0, 0, 0);
        len = 0;
        while (awake_o && len < 4 * WD) begin
            len++;
            case (mode)
                1: step(0, len == IO - 1, 0, 0);
                2: step(0, 0, 0, len <= 3 * IO);
                3: step(0, len % 3 == 0, 0, 1);
                4: step(1, 0, 0, 1);
                default: step(0, 0, 0, 0);
            endcase
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int len;
        int n_req;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1: reset state
        check(!awake_o && !clk_en_o && !sleep_pulse_o && !status_req_o && status_code_o == 0,
              "R1", "reset outputs", {awake_o, clk_en_o, sleep_pulse_o, status_req_o}, 0);
        // R10: activity while asleep is ignored
        for (int i = 0; i < 20; i++) begin
            step(0, 1, i % 2, i % 3 == 0);
            check(!awake_o && !status_req_o, "R10", "asleep activity", awake_o, 0);
        end
        // R2: wake strobe wakes on the next cycle
        step(1, 0, 0, 0);
        check(awake_o && clk_en_o, "R2", "awake after wake", awake_o, 1);
        while (awake_o) step(0, 0, 0, 0);
        // R3 + R9: quiet timeout length and sleep pulse width
        awake_len(0, len);
        check(len == IO, "R3", "quiet awake length", len, IO);
        check(sleep_pulse_o, "R9", "pulse on sleep entry", sleep_pulse_o, 1);
        step(0, 0, 0, 0);
        check(!sleep_pulse_o, "R9", "pulse width one", sleep_pulse_o, 0);
        // R4: token restarts inactivity count
        awake_len(1, len);
        check(len == 2 * IO - 1, "R4", "token restart length", len, 2 * IO - 1);
        // R5: busy suppresses inactivity timer
        awake_len(2, len);
        check(len == 4 * IO, "R5", "busy hold length", len, 4 * IO);
        // R6: watchdog forces sleep while busy and with tokens
        awake_len(3, len);
        check(len == WD, "R6", "watchdog length", len, WD);
        // R7: wake strobes while awake do not restart the watchdog
        awake_len(4, len);
        check(len == WD, "R7", "wake while awake length", len, WD);
        step(0, 0, 0, 0);
        check(!awake_o, "R7", "asleep after watchdog", awake_o, 0);
        // R8: only the first transmit of the awake period requests status
        step(1, 0, 0, 0);
        step(0, 1, 1, 0);
        check(status_req_o && status_code_o == 8'h11, "R8", "first transmit code",
              status_code_o, 8'h11);
        n_req = 0;
        for (int i = 0; i < 5; i++) begin
            step(0, 1, 1, 0);
            n_req += status_req_o;
        end
        check(n_req == 0, "R8", "later transmit requests", n_req, 0);
        while (awake_o) step(0, 0, 0, 0);
        // Random phase, compared against the model every cycle
        begin
            bit b = 0;
            for (int i = 0; i < 20000; i++) begin
                bit t;
                if ($urandom_range(99) < 3) b = !b;
                t = ($urandom_range(99) < 15);
                step($urandom_range(99) < 3, t, t && ($urandom_range(99) < 30), b);
            end
        end
        step(0, 0, 0, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule